// File: doc/BRIEF.md
# Charge Status Flags and Alert-Response Responder

This block keeps the sticky status byte of a battery charge monitor. Each clock it compares the accumulated charge count against a programmable upper and lower limit. It also latches overflow, battery-voltage and supply-lockout events. A host clears the flags with a read strobe, but a flag whose cause is still present survives the read.

When the pin mode selects alert operation, a new flag event pulls an open-drain alert line low. The alert line is released in only one way: the block must win an SMBus Alert Response Address cycle on the two-wire bus. In that cycle the block acknowledges the response address and returns its own seven-bit address followed by a one. It arbitrates bit by bit against other responders, and it gives up at once if a device with a lower address pulls the data line low while this block is sending a one.

The bus lines arrive as clock-synchronous samples. The block drives the data line only through a pull-down enable. All pins are plain level or pulse signals, so no stream handshake is involved.

Top module: `chg_status_alert`

## Requirements
- R1: After reset the status byte reads 80h, and neither the alert pull-down nor the data-line pull-down is active.
- R2: Status bit 3 is set on the clock edge after the charge is strictly greater than the upper limit. A charge equal to the limit leaves it clear.
- R3: Status bit 2 is set on the clock edge after the charge is strictly less than the lower limit. A charge equal to the limit leaves it clear.
- R4: Bit 5 is set by an overflow pulse, bit 1 while the battery-low input is high, and bit 0 by a lockout pulse. Bits 5, 3 and 2 stay set when their cause goes away and no read occurs.
- R5: A read strobe reloads each of bits 5..0 with its present cause: bits whose cause has gone are cleared, and the others stay set. Bit 7 always reads 1, and bits 6 and 4 always read 0.
- R6: With pin mode 10b, a rising edge of any of status bits 5, 3, 2 or 1 asserts the alert pull-down. A rising edge of bit 0 does not. Entering mode 10b while one of those bits is set also counts as a rising edge.
- R7: In pin modes 00b, 01b and 11b the alert pull-down stays inactive, and an alert-response cycle is not acknowledged.
- R8: While the alert is active, a START followed by the byte 19h (address 0001100b plus read bit) is acknowledged. The block then returns C9h (address 1100100b plus 1), MSB first, changing data only while SCL is low.
- R9: If the block is sending a 1 and samples SDA low on a SCL rising edge, it stops driving for the rest of the byte and keeps its alert active. A later alert-response cycle can still win.
- R10: After all eight reply bits are sent without loss, the alert pull-down is released. Further alert-response cycles are not acknowledged until a new flag event occurs.
- R11: Any address byte other than 19h is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| charge | input | CW | Accumulated charge count |
| thr_hi | input | CW | Upper charge limit |
| thr_lo | input | CW | Lower charge limit |
| ovf_evt | input | 1 | One-cycle pulse: charge count hit its top or bottom |
| vbat_low | input | 1 | Battery-voltage comparator output, high when below its limit |
| uvlo_evt | input | 1 | One-cycle pulse: supply lockout occurred |
| pin_mode | input | 2 | Pin mode; 10b selects alert operation |
| stat_rd | input | 1 | One-cycle pulse: host read the status byte |
| scl_in | input | 1 | Synchronized bus clock sample |
| sda_in | input | 1 | Synchronized bus data sample |
| status | output | 8 | Status byte |
| alert_pull | output | 1 | 1 = pull the alert line low |
| sda_pull | output | 1 | 1 = pull the bus data line low |

## Verification
The bench puts the charge exactly on each limit. An off-by-one comparator would raise a flag there that should stay clear. It reads the status byte while some causes persist and others have gone: a design that clears everything would drop a live threshold or battery flag, and one that never clears would keep a stale overflow bit. A second responder pulls SDA low during the first reply bit. A design without arbitration would keep driving and corrupt the byte, and one that treats the loss as a win would drop its alert. The bench also toggles the pin mode with flags pending, which exposes an alert or acknowledge leaking through outside alert mode.

// File: rtl/chg_alert_pkg.sv
package chg_alert_pkg;
  localparam logic [1:0] MODE_ALERT = 2'b10;

  typedef enum logic [2:0] {
    AR_IDLE,
    AR_ADDR,
    AR_ACKW,
    AR_ACK,
    AR_SEND,
    AR_REL
  } ar_state_e;

  // sticky flag order inside the flag vector
  localparam int F_UVLO = 0;
  localparam int F_VBAT = 1;
  localparam int F_LO   = 2;
  localparam int F_HI   = 3;
  localparam int F_OVF  = 4;
  localparam int NFLAG  = 5;
endpackage

// File: rtl/chg_stat_flags.sv
module chg_stat_flags
  import chg_alert_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] charge,
  input  logic [CW-1:0] thr_hi,
  input  logic [CW-1:0] thr_lo,
  input  logic          ovf_evt,
  input  logic          vbat_low,
  input  logic          uvlo_evt,
  input  logic          stat_rd,
  output logic [7:0]    status
);
  logic [NFLAG-1:0] cause;
  logic [NFLAG-1:0] flag;

  always_comb begin
    cause         = '0;
    cause[F_UVLO] = uvlo_evt;
    cause[F_VBAT] = vbat_low;
    cause[F_LO]   = (charge < thr_lo);
    cause[F_HI]   = (charge > thr_hi);
    cause[F_OVF]  = ovf_evt;
  end

  // a read reloads each flag from its live cause; otherwise flags are sticky
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag[i] <= 1'b0;
      else if (stat_rd) flag[i] <= cause[i];
      else              flag[i] <= flag[i] | cause[i];
    end
  end

  assign status = {1'b1, 1'b0, flag[F_OVF], 1'b0,
                   flag[F_HI], flag[F_LO], flag[F_VBAT], flag[F_UVLO]};
endmodule

// File: rtl/chg_alert_ctl.sv
module chg_alert_ctl
  import chg_alert_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [1:0]      pin_mode,
  input  logic            win,
  output logic            alr
);
  logic            mode_ok;
  logic [NSRC-1:0] src_m;
  logic [NSRC-1:0] src_prev;
  logic            evt;

  assign mode_ok = (pin_mode == MODE_ALERT);
  assign src_m   = mode_ok ? src : '0;
  assign evt     = |(src_m & ~src_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev <= '0;
      alr      <= 1'b0;
    end else begin
      src_prev <= src_m;
      if (!mode_ok)  alr <= 1'b0;
      else if (evt)  alr <= 1'b1;
      else if (win)  alr <= 1'b0;
    end
  end
endmodule

// File: rtl/chg_ara_resp.sv
module chg_ara_resp
  import chg_alert_pkg::*;
#(
  parameter logic [6:0] SELF_ADDR = 7'h64,
  parameter logic [6:0] ARA_ADDR  = 7'h0C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  input  logic alr,
  output logic sda_pull,
  output logic win
);
  localparam logic [7:0] ARA_BYTE  = {ARA_ADDR, 1'b1};
  localparam logic [7:0] RESP_BYTE = {SELF_ADDR, 1'b1};

  ar_state_e  st;
  logic       scl_r, sda_r;
  logic [6:0] sh;
  logic [6:0] tx;
  logic [2:0] cnt;
  logic       scl_rise, scl_fall, start_c, stop_c, lost;

  assign scl_rise = scl & ~scl_r;
  assign scl_fall = ~scl & scl_r;
  assign start_c  = scl & scl_r & sda_r & ~sda;
  assign stop_c   = scl & scl_r & ~sda_r & sda;
  assign lost     = ~sda_pull & ~sda;
  assign win      = (st == AR_SEND) && scl_rise && !lost && (cnt == 3'd7)
                    && !start_c && !stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= AR_IDLE;
      scl_r    <= 1'b1;
      sda_r    <= 1'b1;
      sh       <= '0;
      tx       <= '0;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_r <= scl;
      sda_r <= sda;
      if (start_c) begin
        st       <= AR_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= AR_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          AR_ADDR: if (scl_rise) begin
            sh  <= {sh[5:0], sda};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7)
              st <= (({sh, sda} == ARA_BYTE) && alr) ? AR_ACKW : AR_IDLE;
          end
          AR_ACKW: if (scl_fall) begin
            sda_pull <= 1'b1;
            st       <= AR_ACK;
          end
          AR_ACK: if (scl_fall) begin
            tx       <= RESP_BYTE[6:0];
            sda_pull <= ~RESP_BYTE[7];
            cnt      <= '0;
            st       <= AR_SEND;
          end
          AR_SEND: begin
            if (scl_rise) begin
              if (lost)              st  <= AR_IDLE;
              else if (cnt == 3'd7)  st  <= AR_REL;
              else                   cnt <= cnt + 3'd1;
            end else if (scl_fall) begin
              sda_pull <= ~tx[6];
              tx       <= {tx[5:0], 1'b0};
            end
          end
          AR_REL: if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= AR_IDLE;
          end
          default: st <= AR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/chg_status_alert.sv
module chg_status_alert
  import chg_alert_pkg::*;
#(
  parameter int         CW        = 16,
  parameter logic [6:0] SELF_ADDR = 7'h64,
  parameter logic [6:0] ARA_ADDR  = 7'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] charge,
  input  logic [CW-1:0] thr_hi,
  input  logic [CW-1:0] thr_lo,
  input  logic          ovf_evt,
  input  logic          vbat_low,
  input  logic          uvlo_evt,
  input  logic [1:0]    pin_mode,
  input  logic          stat_rd,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic [7:0]    status,
  output logic          alert_pull,
  output logic          sda_pull
);
  logic       alr;
  logic       win;
  logic [3:0] alert_src;

  chg_stat_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .charge(charge), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .ovf_evt(ovf_evt), .vbat_low(vbat_low),
    .uvlo_evt(uvlo_evt), .stat_rd(stat_rd), .status(status)
  );

  assign alert_src = {status[5], status[3], status[2], status[1]};

  chg_alert_ctl #(.NSRC(4)) u_alert (
    .clk(clk), .rst_n(rst_n), .src(alert_src), .pin_mode(pin_mode),
    .win(win), .alr(alr)
  );

  chg_ara_resp #(.SELF_ADDR(SELF_ADDR), .ARA_ADDR(ARA_ADDR)) u_ara (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in), .alr(alr),
    .sda_pull(sda_pull), .win(win)
  );

  assign alert_pull = alr;
endmodule

// File: rtl/chg_status_alert_chk.sv
module chg_status_alert_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] charge,
  input logic [CW-1:0] thr_hi,
  input logic [CW-1:0] thr_lo,
  input logic          stat_rd,
  input logic [1:0]    pin_mode,
  input logic          ovf_flag,
  input logic          hi_flag,
  input logic          lo_flag,
  input logic          alert_pull
);
  // R2
  a_r2_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (charge > thr_hi) |=> hi_flag);
  // R3
  a_r3_lo_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (charge < thr_lo) |=> lo_flag);
  // R4
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_rd) |=> ovf_flag);
  // R5
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(charge > thr_hi)) |=> !hi_flag);
  // R7
  a_r7_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode != 2'b10 && $past(pin_mode) != 2'b10) |-> !alert_pull);
endmodule

bind chg_status_alert chg_status_alert_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .charge(charge), .thr_hi(thr_hi),
  .thr_lo(thr_lo), .stat_rd(stat_rd), .pin_mode(pin_mode),
  .ovf_flag(status[5]), .hi_flag(status[3]), .lo_flag(status[2]),
  .alert_pull(alert_pull)
);

// File: tb/chg_status_alert_bench.sv
module chg_status_alert_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] charge = 16'h8000, thr_hi = 16'h9000, thr_lo = 16'h1000;
  logic        ovf_evt = 1'b0, vbat_low = 1'b0, uvlo_evt = 1'b0, stat_rd = 1'b0;
  logic [1:0]  pin_mode = 2'b10;
  logic        scl_m = 1'b1, sda_m = 1'b1, other = 1'b0;
  logic        sda_bus;
  logic [7:0]  status;
  logic        alert_pull, sda_pull;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~other & ~sda_pull;

  chg_status_alert u_chg_status_alert (
    .clk(clk), .rst_n(rst_n), .charge(charge), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .ovf_evt(ovf_evt), .vbat_low(vbat_low),
    .uvlo_evt(uvlo_evt), .pin_mode(pin_mode), .stat_rd(stat_rd),
    .scl_in(scl_m), .sda_in(sda_bus), .status(status),
    .alert_pull(alert_pull), .sda_pull(sda_pull)
  );

  typedef struct { string tag; logic [7:0] v; } item_t;
  item_t      exp_q[$];
  logic [7:0] obs_q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // driver side: push expected and observed items
  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    item_t it;
    it.tag = tag; it.v = exp;
    exp_q.push_back(it);
    obs_q.push_back(got);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      @(posedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        item_t it;
        logic [7:0] g;
        it = exp_q.pop_front();
        g  = obs_q.pop_front();
        n_chk++;
        if (g !== it.v) begin
          n_bad++;
          $display("FAIL %s got=%h exp=%h", it.tag, g, it.v);
        end
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hold(3);
    sda_m = 1'b0; hold(3);
    scl_m = 1'b0; hold(3);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(3);
    scl_m = 1'b1; hold(3);
    sda_m = 1'b1; hold(3);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(2);
    scl_m = 1'b1; hold(4);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; hold(2);
    scl_m = 1'b1; hold(2);
    b = sda_bus; hold(2);
    scl_m = 1'b0; hold(2);
  endtask

  task automatic bus_txn(input logic [7:0] abyte, input bit fight,
                         output logic ack, output logic [7:0] data);
    logic b;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(abyte[i]);
    read_bit(ack);
    data = 8'hFF;
    if (!ack) begin
      for (int i = 7; i >= 0; i--) begin
        if (fight && i == 7) other = 1'b1;
        read_bit(b);
        other = 1'b0;
        data[i] = b;
      end
      send_bit(1'b1);
    end
    bus_stop();
  endtask

  task automatic rd_pulse();
    stat_rd = 1'b1; hold(1); stat_rd = 1'b0; hold(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    hold(3);
    check("R1 status after reset", status, 8'h80);
    check("R1 alert idle", {7'b0, alert_pull}, 8'h00);
    check("R1 sda idle", {7'b0, sda_pull}, 8'h00);
    rst_n = 1'b1; hold(3);

    charge = 16'h9000; hold(4);
    check("R2 equal to upper limit", status, 8'h80);
    charge = 16'h9001; hold(4);
    check("R2 above upper limit", status, 8'h88);
    check("R6 alert on new flag", {7'b0, alert_pull}, 8'h01);
    charge = 16'h8000; hold(4);
    check("R4 upper flag sticky", status, 8'h88);

    bus_txn(8'h19, 1'b0, ack, d);
    check("R8 ack of response addr", {7'b0, ack}, 8'h00);
    check("R8 reply byte", d, 8'hC9);
    hold(2);
    check("R10 alert released after win", {7'b0, alert_pull}, 8'h00);
    bus_txn(8'h19, 1'b0, ack, d);
    check("R10 no ack after win", {7'b0, ack}, 8'h01);

    rd_pulse();
    check("R5 read clears gone cause", status, 8'h80);
    charge = 16'h1000; hold(4);
    check("R3 equal to lower limit", status, 8'h80);
    charge = 16'h0FFF; hold(4);
    check("R3 below lower limit", status, 8'h84);
    check("R10 new event re-arms alert", {7'b0, alert_pull}, 8'h01);
    rd_pulse();
    check("R5 read keeps live cause", status, 8'h84);

    bus_txn(8'h19, 1'b1, ack, d);
    check("R9 ack before arbitration", {7'b0, ack}, 8'h00);
    check("R9 lost byte released", d, 8'h7F);
    check("R9 alert kept after loss", {7'b0, alert_pull}, 8'h01);
    bus_txn(8'h19, 1'b0, ack, d);
    check("R9 retry wins", d, 8'hC9);
    hold(2);
    check("R9 alert released on retry", {7'b0, alert_pull}, 8'h00);

    uvlo_evt = 1'b1; hold(1); uvlo_evt = 1'b0; hold(4);
    check("R4 lockout flag", status, 8'h85);
    check("R6 lockout gives no alert", {7'b0, alert_pull}, 8'h00);

    ovf_evt = 1'b1; vbat_low = 1'b1; hold(1); ovf_evt = 1'b0; hold(4);
    check("R4 overflow and battery flags", status, 8'hA7);
    check("R6 alert on overflow", {7'b0, alert_pull}, 8'h01);
    rd_pulse();
    check("R5 mixed read", status, 8'h86);

    bus_txn(8'hC8, 1'b0, ack, d);
    check("R11 other address no ack", {7'b0, ack}, 8'h01);

    pin_mode = 2'b01; hold(4);
    check("R7 mode 01 alert quiet", {7'b0, alert_pull}, 8'h00);
    bus_txn(8'h19, 1'b0, ack, d);
    check("R7 mode 01 no ack", {7'b0, ack}, 8'h01);
    pin_mode = 2'b00; hold(4);
    check("R7 mode 00 alert quiet", {7'b0, alert_pull}, 8'h00);
    pin_mode = 2'b10; hold(4);
    check("R6 entering alert mode with flags", {7'b0, alert_pull}, 8'h01);

    hold(10);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule